// File: doc/BRIEF.md
# XIP Access Window and Security Filter

This block sits in front of an execute-in-place memory path. It classifies every incoming bus request by the region it targets and checks it against per-security-state permission rules. It then hands a decoded result to the cache and serial-memory stages that follow. Each result says one of two things. Either the access takes a bus error, or it proceeds with a cache-lookup enable, an effective write flag, a marker for a write that was turned into a read, and an optional fixed cache way. The block also holds the 12-bit control word that sets these rules. That word is written only from the secure state.

Requests enter on a valid/ready channel, and results leave one cycle later on a valid/ready channel. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, every result field holds steady. The control port is a plain one-cycle write strobe with a continuous read-back.

Top module: `xip_gate`

## Requirements
- R1: Address bits [27:26] select the region: 0 cached, 1 uncached, 2 maintenance, 3 untranslated. In the uncached region, control bit 4 blocks secure accesses with a bus error and control bit 5 blocks non-secure accesses. Neither bit affects region 3.
- R2: A non-secure access to region 3 takes a bus error while control bit 7 is 1. Bit 7 is 1 after reset.
- R3: A secure access to region 3 takes a bus error only while control bit 6 is 1. Bit 6 is 0 after reset.
- R4: A non-secure access to region 2 takes a bus error unless control bit 8 is 1. Secure accesses to region 2 never take an error from this rule.
- R5: Address bit 24 selects memory window 0 or window 1. Control bit 10 makes window 0 writable and bit 11 makes window 1 writable. A write to a window that is not writable is not rejected: `rsp_write` is 0 and `rsp_downgraded` is 1. Maintenance-region writes pass through unchanged.
- R6: `rsp_cache_query` is 1 only for region 0 and only while the cache enable for the request's state is 1. Bit 0 is the secure enable and bit 1 is the non-secure enable.
- R7: A control write whose bit 3 (power-down) is 1 stores 0 in both cache enables, whatever values it carries for them.
- R8: While control bit 9 is 1, a cached access that queries the cache has `rsp_way_fixed` set. `rsp_way` is 0 for secure and 1 for non-secure.
- R9: The control word resets to 0x083. Writes with `cfg_wr_secure` low leave it unchanged. Bit 2 always reads 0.
- R10: A result with `rsp_bus_err` set has `rsp_cache_query`, `rsp_write` and `rsp_downgraded` all 0.
- R11: A result appears one cycle after acceptance. All result fields hold while `rsp_ready` is low, and a new request is taken in the same cycle that the held result drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_secure | input | 1 | Security state of the control write |
| cfg_wr_data | input | 12 | Control word write data |
| cfg_rd_data | output | 12 | Current control word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | Request is a write |
| req_secure | input | 1 | Request is from the secure state |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Downstream takes the result |
| rsp_addr | output | ADDR_W | Address of the decoded request |
| rsp_bus_err | output | 1 | Access rejected with a bus error |
| rsp_cache_query | output | 1 | Cache lookup enabled |
| rsp_write | output | 1 | Effective write after permission checks |
| rsp_downgraded | output | 1 | Write was turned into a read |
| rsp_way_fixed | output | 1 | Way is forced by partitioning |
| rsp_way | output | 1 | Forced way index |

## Verification
The hardest case to reach is the one where back-pressure and a new request meet. A result must stay frozen while a second request waits. That second request must then be taken in the very cycle the first result drains. The bench holds `rsp_ready` low across a full cycle with another request pending, checks the stalled fields and `req_ready`, then releases both in one edge. The other hard area is how control bits combine, such as power-down racing with enables written in the same word. Each combination is reached by a secure control write followed immediately by probe requests.

// File: rtl/xip_gate_pkg.sv
package xip_gate_pkg;
  localparam int CTRL_W      = 12;
  localparam int B_EN_S      = 0;
  localparam int B_EN_NS     = 1;
  localparam int B_PD        = 3;
  localparam int B_UNC_S     = 4;
  localparam int B_UNC_NS    = 5;
  localparam int B_UNT_S     = 6;
  localparam int B_UNT_NS    = 7;
  localparam int B_MAINT_NS  = 8;
  localparam int B_SPLIT     = 9;
  localparam int B_WR_W0     = 10;
  localparam int B_WR_W1     = 11;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 12'h083;
  localparam logic [CTRL_W-1:0] CTRL_MASK  = 12'hFFB;

  typedef enum logic [1:0] {
    RGN_CACHED   = 2'd0,
    RGN_UNCACHED = 2'd1,
    RGN_MAINT    = 2'd2,
    RGN_UNTRANS  = 2'd3
  } region_e;

  typedef struct packed {
    logic bus_err;
    logic cache_query;
    logic write;
    logic downgraded;
    logic way_fixed;
    logic way;
  } verdict_t;
endpackage

// File: rtl/xip_ctrl_word.sv
module xip_ctrl_word
  import xip_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_secure,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && wr_secure) begin
      ctrl_d = wr_data & CTRL_MASK;
      if (wr_data[B_PD]) begin
        ctrl_d[B_EN_S]  = 1'b0;
        ctrl_d[B_EN_NS] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else        ctrl_q <= ctrl_d;
  end

  a_r7_pd_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_secure && wr_data[B_PD] |=> !ctrl_q[B_EN_S] && !ctrl_q[B_EN_NS]);

  a_r9_ns_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_secure |=> $stable(ctrl_q));
endmodule

// File: rtl/xip_decode.sv
module xip_decode
  import xip_gate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 26,
  parameter int WINDOW_BIT = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              secure,
  input  logic [CTRL_W-1:0] ctrl,
  output verdict_t          verdict
);
  region_e rgn;
  logic    blocked;
  logic    win_writable;
  logic    en_for_state;

  assign rgn          = region_e'(addr[REGION_LSB+1:REGION_LSB]);
  assign win_writable = addr[WINDOW_BIT] ? ctrl[B_WR_W1] : ctrl[B_WR_W0];
  assign en_for_state = secure ? ctrl[B_EN_S] : ctrl[B_EN_NS];

  always_comb begin
    unique case (rgn)
      RGN_UNCACHED: blocked = secure ? ctrl[B_UNC_S] : ctrl[B_UNC_NS];
      RGN_UNTRANS:  blocked = secure ? ctrl[B_UNT_S] : ctrl[B_UNT_NS];
      RGN_MAINT:    blocked = !secure && !ctrl[B_MAINT_NS];
      default:      blocked = 1'b0;
    endcase
  end

  always_comb begin
    verdict             = '0;
    verdict.bus_err     = blocked;
    verdict.cache_query = !blocked && (rgn == RGN_CACHED) && en_for_state;
    if (!blocked && write) begin
      if (rgn == RGN_MAINT || win_writable) verdict.write = 1'b1;
      else                                  verdict.downgraded = 1'b1;
    end
    verdict.way_fixed = verdict.cache_query && ctrl[B_SPLIT];
    verdict.way       = verdict.way_fixed && !secure;
  end
endmodule

// File: rtl/xip_rsp_stage.sv
module xip_rsp_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r11_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/xip_gate.sv
module xip_gate
  import xip_gate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 26,
  parameter int WINDOW_BIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_secure,
  input  logic [11:0]       cfg_wr_data,
  output logic [11:0]       cfg_rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_secure,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_bus_err,
  output logic              rsp_cache_query,
  output logic              rsp_write,
  output logic              rsp_downgraded,
  output logic              rsp_way_fixed,
  output logic              rsp_way
);
  localparam int VW = $bits(verdict_t);
  localparam int PW = ADDR_W + VW;

  logic [CTRL_W-1:0] ctrl;
  verdict_t          verdict, rsp_v;
  logic [PW-1:0]     rsp_payload;

  xip_ctrl_word u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_secure(cfg_wr_secure),
    .wr_data(cfg_wr_data), .ctrl_q(ctrl)
  );

  xip_decode #(.ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB), .WINDOW_BIT(WINDOW_BIT)) u_dec (
    .addr(req_addr), .write(req_write), .secure(req_secure), .ctrl(ctrl),
    .verdict(verdict)
  );

  xip_rsp_stage #(.W(PW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data({req_addr, verdict}),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(rsp_payload)
  );

  assign cfg_rd_data     = ctrl;
  assign rsp_addr        = rsp_payload[PW-1:VW];
  assign rsp_v           = verdict_t'(rsp_payload[VW-1:0]);
  assign rsp_bus_err     = rsp_v.bus_err;
  assign rsp_cache_query = rsp_v.cache_query;
  assign rsp_write       = rsp_v.write;
  assign rsp_downgraded  = rsp_v.downgraded;
  assign rsp_way_fixed   = rsp_v.way_fixed;
  assign rsp_way         = rsp_v.way;

  a_r10_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_bus_err |-> !rsp_cache_query && !rsp_write && !rsp_downgraded);

  a_r6_query_cached_only: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cache_query |-> rsp_addr[REGION_LSB+1:REGION_LSB] == 2'd0);

  a_r8_way_needs_query: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_way_fixed |-> rsp_cache_query);
endmodule

// File: tb/xip_gate_tb_top.sv
`timescale 1ns/1ps
module xip_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_wr_secure = 1'b0;
  logic [11:0] cfg_wr_data = '0, cfg_rd_data;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_secure = 1'b0;
  logic [31:0] req_addr = '0, rsp_addr;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic        rsp_bus_err, rsp_cache_query, rsp_write, rsp_downgraded, rsp_way_fixed, rsp_way;
  int          n_chk = 0, n_fail = 0;

  localparam logic [31:0] A_CACHED = 32'h1000_0040;
  localparam logic [31:0] A_UNC    = 32'h1400_0040;
  localparam logic [31:0] A_MAINT  = 32'h1800_0040;
  localparam logic [31:0] A_UNT    = 32'h1C00_0040;
  localparam logic [31:0] A_WIN1   = 32'h0100_0000;

  always #5 clk = ~clk;

  xip_gate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_secure(cfg_wr_secure),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_secure(req_secure),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_bus_err(rsp_bus_err), .rsp_cache_query(rsp_cache_query), .rsp_write(rsp_write),
    .rsp_downgraded(rsp_downgraded), .rsp_way_fixed(rsp_way_fixed), .rsp_way(rsp_way)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", what, got, exp);
    end
  endtask

  task automatic cfg(input logic sec, input logic [11:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_secure = sec; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // drives one request, samples its result one cycle later
  task automatic probe(input logic [31:0] a, input logic wr, input logic sec);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_secure = sec;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // expected {err,query,write,downgraded,way_fixed,way}
  task automatic expect_rsp(input string tag, input logic [5:0] exp);
    chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " verdict"}, {26'd0, rsp_bus_err, rsp_cache_query, rsp_write,
                           rsp_downgraded, rsp_way_fixed, rsp_way}, {26'd0, exp});
  endtask

  task automatic t_reset();
    chk("R9 reset ctrl", {20'd0, cfg_rd_data}, 32'h083);
    chk("R11 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R11 reset req_ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_cached();
    probe(A_CACHED, 1'b0, 1'b1); expect_rsp("R6 sec cached", 6'b010000);
    chk("R11 addr passed", rsp_addr, A_CACHED);
    probe(A_CACHED, 1'b0, 1'b0); expect_rsp("R6 ns cached", 6'b010000);
    probe(A_UNC, 1'b0, 1'b1);    expect_rsp("R1 uncached no query", 6'b000000);
  endtask

  task automatic t_uncached();
    cfg(1'b1, 12'h0B3);
    probe(A_UNC, 1'b0, 1'b1); expect_rsp("R1 uncached sec blocked", 6'b100000);
    probe(A_UNC, 1'b0, 1'b0); expect_rsp("R1 uncached ns blocked", 6'b100000);
    probe(A_UNT, 1'b0, 1'b1); expect_rsp("R1 untranslated unaffected", 6'b000000);
    cfg(1'b1, 12'h093);
    probe(A_UNC, 1'b0, 1'b1); expect_rsp("R1 bit4 sec only", 6'b100000);
    probe(A_UNC, 1'b0, 1'b0); expect_rsp("R1 bit4 leaves ns", 6'b000000);
    cfg(1'b1, 12'h083);
  endtask

  task automatic t_untrans();
    probe(A_UNT, 1'b0, 1'b0); expect_rsp("R2 ns untranslated reset", 6'b100000);
    probe(A_UNT, 1'b0, 1'b1); expect_rsp("R3 sec untranslated reset", 6'b000000);
    cfg(1'b1, 12'h0C3);
    probe(A_UNT, 1'b0, 1'b1); expect_rsp("R3 sec blocked bit6", 6'b100000);
    cfg(1'b1, 12'h003);
    probe(A_UNT, 1'b0, 1'b0); expect_rsp("R2 ns allowed bit7 clear", 6'b000000);
    cfg(1'b1, 12'h083);
  endtask

  task automatic t_maint();
    probe(A_MAINT, 1'b1, 1'b0); expect_rsp("R4 ns maint blocked", 6'b100000);
    probe(A_MAINT, 1'b1, 1'b1); expect_rsp("R4 sec maint write", 6'b001000);
    cfg(1'b1, 12'h183);
    probe(A_MAINT, 1'b1, 1'b0); expect_rsp("R4 ns maint permitted", 6'b001000);
    cfg(1'b1, 12'h083);
  endtask

  task automatic t_write();
    probe(A_CACHED, 1'b1, 1'b1);          expect_rsp("R5 w0 downgraded", 6'b010100);
    probe(A_CACHED | A_WIN1, 1'b1, 1'b1); expect_rsp("R5 w1 downgraded", 6'b010100);
    cfg(1'b1, 12'h483);
    probe(A_CACHED, 1'b1, 1'b1);          expect_rsp("R5 w0 writable", 6'b011000);
    probe(A_CACHED | A_WIN1, 1'b1, 1'b0); expect_rsp("R5 w1 still ro", 6'b010100);
    cfg(1'b1, 12'h883);
    probe(A_UNC | A_WIN1, 1'b1, 1'b0);    expect_rsp("R5 w1 writable uncached", 6'b001000);
    probe(A_UNC, 1'b1, 1'b0);             expect_rsp("R5 w0 ro again", 6'b000100);
    cfg(1'b1, 12'h083);
  endtask

  task automatic t_err_write();
    probe(A_UNT, 1'b1, 1'b0); expect_rsp("R10 err write silent", 6'b100000);
    cfg(1'b1, 12'hC83);
    probe(A_UNT, 1'b1, 1'b0); expect_rsp("R10 err writable silent", 6'b100000);
    cfg(1'b1, 12'h083);
  endtask

  task automatic t_enable();
    cfg(1'b1, 12'h082);
    probe(A_CACHED, 1'b0, 1'b1); expect_rsp("R6 sec disabled", 6'b000000);
    probe(A_CACHED, 1'b0, 1'b0); expect_rsp("R6 ns still on", 6'b010000);
    cfg(1'b1, 12'h081);
    probe(A_CACHED, 1'b0, 1'b0); expect_rsp("R6 ns disabled", 6'b000000);
    probe(A_CACHED, 1'b0, 1'b1); expect_rsp("R6 sec on", 6'b010000);
    cfg(1'b1, 12'h083);
  endtask

  task automatic t_pd();
    cfg(1'b1, 12'h08B);
    chk("R7 pd clears enables", {20'd0, cfg_rd_data}, 32'h088);
    probe(A_CACHED, 1'b0, 1'b1); expect_rsp("R7 no query powered down", 6'b000000);
    cfg(1'b1, 12'h083);
    chk("R7 re-enable after pd", {20'd0, cfg_rd_data}, 32'h083);
    probe(A_CACHED, 1'b0, 1'b1); expect_rsp("R7 query back", 6'b010000);
  endtask

  task automatic t_split();
    cfg(1'b1, 12'h283);
    probe(A_CACHED, 1'b0, 1'b1); expect_rsp("R8 sec way0", 6'b010010);
    probe(A_CACHED, 1'b0, 1'b0); expect_rsp("R8 ns way1", 6'b010011);
    probe(A_UNC, 1'b0, 1'b0);    expect_rsp("R8 uncached no way", 6'b000000);
    cfg(1'b1, 12'h083);
    probe(A_CACHED, 1'b0, 1'b0); expect_rsp("R8 split off", 6'b010000);
  endtask

  task automatic t_ns_cfg();
    cfg(1'b0, 12'hFFF);
    chk("R9 ns write ignored", {20'd0, cfg_rd_data}, 32'h083);
    cfg(1'b1, 12'h087);
    chk("R9 bit2 reads zero", {20'd0, cfg_rd_data}, 32'h083);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = A_CACHED; req_write = 1'b0; req_secure = 1'b1;
    @(negedge clk);
    req_addr = A_UNT; req_secure = 1'b0;
    chk("R11 first result", rsp_addr, A_CACHED);
    chk("R11 ready low when stalled", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R11 held addr", rsp_addr, A_CACHED);
    chk("R11 held query", {31'd0, rsp_cache_query}, 32'd1);
    chk("R11 ready tracks drain", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 next taken on drain", rsp_addr, A_UNT);
    expect_rsp("R11 second verdict", 6'b100000);
    @(negedge clk);
    chk("R11 empty after drain", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cached();
    t_uncached();
    t_untrans();
    t_maint();
    t_write();
    t_err_write();
    t_enable();
    t_pd();
    t_split();
    t_ns_cfg();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule